// File: doc/BRIEF.md
# I2C Byte-Step Bus Controller

This block is the controlling end of a two-wire serial bus. A host drives it one step at a time. A step with `cmd_start` set claims the bus and sends the 7-bit target address and the direction flag. The controller waits for both lines to be high before it claims an idle bus. If it already holds the bus, it issues a repeated START. A step without `cmd_start` moves one data byte, either out to the target or in from it, according to the direction latched by the last address step. When `cmd_last` is set, the controller releases the bus with a STOP once the step completes.

Both lines are open drain. The block never drives a line high: `scl_oe` and `sda_oe` are pull-low enables, and the external pull-ups make the high level. The two line inputs pass through a two-flop synchronizer before any decision uses them. Each SCL period is four quarter phases. The length of one quarter, in system clocks, comes from `cfg_div`, so the host picks standard or fast bus rates by choosing a divider for its clock.

Between steps the controller holds SCL low and pulses `done`. The host then presents the next step. If the target does not acknowledge an address or a written byte, the controller ends the transfer with a STOP. It then pulses `nack_error` together with `done`.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `scl_oe` and `sda_oe` are both 0, and `done` and `nack_error` are 0 until a step completes.
- R2: A step with `cmd_start=1` accepted while idle raises `busy` on the next clock. The controller then drives neither line until it has seen both lines high at the end of a quarter phase.
- R3: A START is SDA falling while SCL is high, followed by SCL falling. A STOP is SCL rising while SDA is low, followed by SDA rising while SCL is high.
- R4: Apart from START and STOP, SDA changes only while SCL is low.
- R5: The first byte after a START is `{cmd_addr, cmd_rw}`, where `cmd_rw=1` means read and sits in bit 0. Every byte goes out MSB first.
- R6: On the ninth clock of an address or written byte, the controller releases SDA and samples it. A low level is an ACK. If `cmd_last=0`, an ACK leaves SCL held low and `busy` high, and `done` pulses.
- R7: A high level on that ninth clock (no ACK) makes the controller generate a STOP. At the end of that STOP, `done` and `nack_error` pulse in the same cycle and `busy` falls.
- R8: In a read byte, the controller releases SDA for the eight data clocks and assembles `rd_data` MSB first. On the ninth clock it drives ACK (low) when `cmd_last=0`, or NACK (high) followed by a STOP when `cmd_last=1`.
- R9: A step with `cmd_start=1` accepted while the bus is held after an address or written byte issues a repeated START with no STOP before it.
- R10: One quarter phase lasts `max(cfg_div, 2)` clocks. Within a byte, SCL stays high for two quarters of each bit.
- R11: `cmd_go` has no effect while a step is in progress, or while idle with `cmd_start=0`.
- R12: `busy` stays high from the accepted START step until its STOP completes. `done` is high for exactly one cycle per completed step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | System clocks per quarter phase (values below 2 act as 2) |
| cmd_go | input | 1 | One-cycle request to run a step |
| cmd_start | input | 1 | Step begins with a START or repeated START and sends the address |
| cmd_addr | input | 7 | Target address for an address step |
| cmd_rw | input | 1 | Direction for an address step: 1 read, 0 write |
| cmd_wdata | input | 8 | Byte to send in a write data step |
| cmd_last | input | 1 | Finish with a STOP after this step |
| rd_data | output | 8 | Byte received by the latest read step |
| busy | output | 1 | Bus owned by this controller |
| done | output | 1 | One-cycle pulse when a step completes |
| nack_error | output | 1 | One-cycle pulse when a transfer ended for a missing ACK |
| scl_i | input | 1 | Level on the clock line |
| sda_i | input | 1 | Level on the data line |
| scl_oe | output | 1 | Pull the clock line low |
| sda_oe | output | 1 | Pull the data line low |

## Verification
The assertions check on every cycle that:
- both lines are released whenever the bus is not owned;
- a START from idle follows a bus-free observation;
- SDA moves with SCL high only inside START and STOP;
- the controller lets go of SDA during read data clocks and during the ACK clock of bytes it sends;
- `nack_error` appears only together with `done` and a released bus;
- `done` is a single-cycle pulse;
- quarter ticks are never back to back.

Only the bench scenarios, run against a modelled target on the wired-AND lines, can show the rest:
- the address and data bytes, bit by bit, and the received read data;
- the ACK/NACK sequence the target sees;
- START and STOP counts, including repeated START;
- the measured SCL high time for several dividers;
- the wait on a line held low;
- commands that must be ignored.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int ADDR_BITS = 7;
  localparam int DATA_BITS = 8;
  localparam int BIT_W     = $clog2(DATA_BITS + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RSTA,
    ST_STA_H,
    ST_STA_L,
    ST_BIT,
    ST_HOLD,
    ST_STOP
  } ctl_state_t;

  // Level the controller wants on SDA for the coming bit.
  function automatic logic bit_level(input logic tx_dir, input logic at_ack,
                                     input logic msb, input logic last);
    if (!at_ack) return tx_dir ? msb : 1'b1;
    return tx_dir ? 1'b1 : last;
  endfunction
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '1;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cm_quarter_tick.sv
module i2cm_quarter_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // A quarter lasts max(div,2) clocks, so the terminal count is that minus one.
  function automatic logic [DIV_W-1:0] quarter_limit(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? DIV_W'(1) : d - DIV_W'(1);
  endfunction

  assign lim  = quarter_limit(div);
  assign tick = en && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end

  assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  output logic                 tick_en,
  input  logic                 cmd_go,
  input  logic                 cmd_start,
  input  logic [ADDR_BITS-1:0] cmd_addr,
  input  logic                 cmd_rw,
  input  logic [DATA_BITS-1:0] cmd_wdata,
  input  logic                 cmd_last,
  input  logic                 scl_s,
  input  logic                 sda_s,
  output logic                 scl_lvl,
  output logic                 sda_lvl,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 busy,
  output logic                 done,
  output logic                 nack_error
);
  ctl_state_t           st;
  logic [1:0]           ph;
  logic [BIT_W-1:0]     bidx;
  logic [DATA_BITS-1:0] sh, rx, rd_q;
  logic is_addr, rw_q, last_q, nack_q;
  logic scl_q, sda_q, busy_q, done_q, nerr_q;

  // Named events for the assertions
  logic bus_free, tx_dir, at_ack, sample_ev, ack_missing, stop_end_ev;
  assign bus_free    = scl_s & sda_s;
  assign tx_dir      = is_addr | ~rw_q;
  assign at_ack      = (bidx == BIT_W'(DATA_BITS));
  assign sample_ev   = tick && (st == ST_BIT) && (ph == 2'd3);
  assign ack_missing = sample_ev && at_ack && tx_dir && sda_s;
  assign stop_end_ev = tick && (st == ST_STOP) && (ph == 2'd3);

  assign tick_en = (st != ST_IDLE) && (st != ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bidx <= '0;
      sh <= '0; rx <= '0; rd_q <= '0;
      is_addr <= 1'b0; rw_q <= 1'b0; last_q <= 1'b0; nack_q <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
      busy_q <= 1'b0; done_q <= 1'b0; nerr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      nerr_q <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_go && cmd_start) begin
          st <= ST_WAIT; busy_q <= 1'b1;
          sh <= {cmd_addr, cmd_rw}; rw_q <= cmd_rw; last_q <= cmd_last;
          is_addr <= 1'b1; nack_q <= 1'b0;
        end
        ST_WAIT: if (tick && bus_free) st <= ST_STA_H;
        ST_RSTA: if (tick) begin scl_q <= 1'b1; st <= ST_STA_H; end
        ST_STA_H: if (tick) begin sda_q <= 1'b0; st <= ST_STA_L; end
        ST_STA_L: if (tick) begin
          scl_q <= 1'b0; st <= ST_BIT; ph <= 2'd0; bidx <= '0;
        end
        ST_BIT: if (tick) begin
          case (ph)
            2'd0: begin
              sda_q <= bit_level(tx_dir, at_ack, sh[DATA_BITS-1], last_q);
              ph <= 2'd1;
            end
            2'd1: begin scl_q <= 1'b1; ph <= 2'd2; end
            2'd2: ph <= 2'd3;
            default: begin
              scl_q <= 1'b0; ph <= 2'd0;
              if (!at_ack) begin
                bidx <= bidx + 1'b1;
                sh   <= {sh[DATA_BITS-2:0], 1'b0};
                rx   <= {rx[DATA_BITS-2:0], sda_s};
              end else begin
                if (!tx_dir) rd_q <= rx;
                if (ack_missing) begin
                  nack_q <= 1'b1; st <= ST_STOP;
                end else if (last_q) begin
                  st <= ST_STOP;
                end else begin
                  st <= ST_HOLD; done_q <= 1'b1; is_addr <= 1'b0;
                end
              end
            end
          endcase
        end
        ST_HOLD: if (cmd_go) begin
          last_q <= cmd_last;
          if (cmd_start) begin
            st <= ST_RSTA; sda_q <= 1'b1;
            sh <= {cmd_addr, cmd_rw}; rw_q <= cmd_rw; is_addr <= 1'b1;
          end else begin
            st <= ST_BIT; ph <= 2'd0; bidx <= '0;
            sh <= cmd_wdata; is_addr <= 1'b0;
          end
        end
        ST_STOP: if (tick) begin
          case (ph)
            2'd0: begin sda_q <= 1'b0; ph <= 2'd1; end
            2'd1: begin scl_q <= 1'b1; ph <= 2'd2; end
            2'd2: begin sda_q <= 1'b1; ph <= 2'd3; end
            default: begin
              st <= ST_IDLE; ph <= 2'd0; busy_q <= 1'b0;
              done_q <= 1'b1; nerr_q <= nack_q; nack_q <= 1'b0;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign scl_lvl    = scl_q;
  assign sda_lvl    = sda_q;
  assign rd_data    = rd_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign nack_error = nerr_q;

  assert_release_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (scl_q && sda_q));

  assert_free_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STA_H && $past(st) == ST_WAIT) |-> $past(bus_free));

  assert_sda_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q) && !$stable(sda_q)) |-> (st == ST_STA_L || st == ST_STOP));

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && scl_q && tx_dir && at_ack) |-> sda_q);

  assert_nack_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nerr_q |-> (done_q && !busy_q && scl_q && sda_q));

  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && scl_q && !tx_dir && !at_ack) |-> sda_q);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_hold_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> (!scl_q && busy_q));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic                 cmd_go,
  input  logic                 cmd_start,
  input  logic [ADDR_BITS-1:0] cmd_addr,
  input  logic                 cmd_rw,
  input  logic [DATA_BITS-1:0] cmd_wdata,
  input  logic                 cmd_last,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 busy,
  output logic                 done,
  output logic                 nack_error,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 scl_oe,
  output logic                 sda_oe
);
  logic [1:0] lines_s;
  logic       tick, tick_en, scl_lvl, sda_lvl;

  i2cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s)
  );

  i2cm_quarter_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .div(cfg_div), .tick(tick)
  );

  i2cm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tick_en(tick_en),
    .cmd_go(cmd_go), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_rw(cmd_rw), .cmd_wdata(cmd_wdata), .cmd_last(cmd_last),
    .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .rd_data(rd_data), .busy(busy), .done(done), .nack_error(nack_error)
  );

  assign scl_oe = ~scl_lvl;
  assign sda_oe = ~sda_lvl;
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [11:0] cfg_div = 12'd5;
  logic        cmd_go = 1'b0, cmd_start = 1'b0, cmd_rw = 1'b0, cmd_last = 1'b0;
  logic [6:0]  cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic [7:0]  rd_data;
  logic        busy, done, nack_error, scl_oe, sda_oe;
  logic        slv_pull = 1'b0, force_scl_low = 1'b0;
  wire         scl_line = ~(scl_oe | force_scl_low);
  wire         sda_line = ~(sda_oe | slv_pull);

  i2c_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cmd_go(cmd_go),
    .cmd_start(cmd_start), .cmd_addr(cmd_addr), .cmd_rw(cmd_rw),
    .cmd_wdata(cmd_wdata), .cmd_last(cmd_last), .rd_data(rd_data),
    .busy(busy), .done(done), .nack_error(nack_error),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bq(input int div);
    return (div < 2) ? 2 : div;
  endfunction
  function automatic logic [7:0] first_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  // ---------------- target model on the wired-AND lines ----------------
  localparam logic [6:0] SLV = 7'h2A;
  logic       acc_wr = 1'b1;
  logic [7:0] rd_src [16];
  int         rd_i = 0;
  int         n_start = 0, n_stop = 0, n_wr = 0, n_mack = 0;
  logic [7:0] wr_log [256];
  logic       m_ack [256];
  logic [7:0] addr_log = '0;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  logic       s_act = 1'b0, s_ap = 1'b0, s_rd = 1'b0, s_sel = 1'b0, s_mnack = 1'b0;
  logic [7:0] s_sh = '0, s_out = '0;
  int         sbit = 0;

  always @(scl_line or sda_line) begin
    if (scl_line === prev_scl) begin
      if (scl_line === 1'b1 && prev_sda === 1'b1 && sda_line === 1'b0) begin
        n_start++; s_act = 1; s_ap = 1; s_rd = 0; s_sel = 0; sbit = 0; slv_pull = 0;
      end else if (scl_line === 1'b1 && prev_sda === 1'b0 && sda_line === 1'b1 && s_act) begin
        n_stop++; s_act = 0; slv_pull = 0;
      end
    end else if (scl_line === 1'b1 && s_act) begin
      if (sbit < 8) s_sh = {s_sh[6:0], sda_line};
      else if (s_rd && s_sel && !s_ap) begin
        m_ack[n_mack[7:0]] = sda_line; n_mack++; s_mnack = sda_line;
      end
      sbit++;
    end else if (scl_line === 1'b0 && s_act) begin
      if (sbit == 8) begin
        if (s_ap) begin
          addr_log = s_sh; s_sel = (s_sh[7:1] == SLV); s_rd = s_sh[0]; slv_pull = s_sel;
        end else if (!s_rd) begin
          if (s_sel) begin wr_log[n_wr[7:0]] = s_sh; n_wr++; slv_pull = acc_wr; end
        end else slv_pull = 0;
      end else if (sbit == 9) begin
        sbit = 0;
        if (s_sel && s_rd && (s_ap || !s_mnack)) begin
          s_out = rd_src[rd_i[3:0]]; rd_i++; slv_pull = !s_out[7];
        end else slv_pull = 0;
        s_ap = 0;
      end else if (sbit >= 1 && sbit < 8 && s_sel && s_rd && !s_ap) begin
        slv_pull = !s_out[7 - sbit];
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // SCL high-time monitor
  int hi_run = 0, last_hi = 0;
  always @(negedge clk) begin
    if (!scl_oe && !force_scl_low) hi_run++;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  // ---------------- host side ----------------
  task automatic issue(input logic st, input logic [6:0] a, input logic rw,
                       input logic [7:0] wd, input logic lst);
    @(negedge clk);
    cmd_go = 1; cmd_start = st; cmd_addr = a; cmd_rw = rw; cmd_wdata = wd; cmd_last = lst;
    @(negedge clk);
    cmd_go = 0;
  endtask

  task automatic wait_done(output logic [7:0] rd, output logic nk);
    while (done !== 1'b1) @(negedge clk);
    rd = rd_data; nk = nack_error;
    @(negedge clk);
    chk(done == 1'b0, "R12", "done width", int'(done), 0);
  endtask

  task automatic step(input logic st, input logic [6:0] a, input logic rw,
                      input logic [7:0] wd, input logic lst,
                      output logic [7:0] rd, output logic nk);
    issue(st, a, rw, wd, lst);
    wait_done(rd, nk);
  endtask

  task automatic do_write(input logic [6:0] a, input int n);
    logic [7:0] wd [4];
    logic [7:0] rd;
    logic nk;
    int ns = n_start, np = n_stop, nw = n_wr;
    step(1, a, 0, 8'h00, 0, rd, nk);
    chk(nk == 0, "R6", "address ack", int'(nk), 0);
    chk(busy == 1 && scl_oe == 1, "R6", "bus held after ack", int'({busy, scl_oe}), 3);
    chk(last_hi == 2 * bq(int'(cfg_div)), "R10", "scl high cycles", last_hi, 2 * bq(int'(cfg_div)));
    for (int i = 0; i < n; i++) begin
      wd[i] = 8'($urandom);
      step(0, a, 0, wd[i], (i == n - 1), rd, nk);
      chk(nk == 0, "R6", "write ack", int'(nk), 0);
    end
    chk(addr_log == first_byte(a, 0), "R5", "address byte", int'(addr_log), int'(first_byte(a, 0)));
    for (int i = 0; i < n; i++)
      chk(wr_log[8'(nw + i)] == wd[i], "R5", "written byte", int'(wr_log[8'(nw + i)]), int'(wd[i]));
    chk(n_start == ns + 1 && n_stop == np + 1, "R3", "start/stop count",
        (n_start - ns) * 16 + (n_stop - np), 17);
    chk(busy == 0, "R12", "busy after stop", int'(busy), 0);
  endtask

  task automatic do_read(input logic [6:0] a, input int n);
    logic [7:0] rd;
    logic nk;
    int nm = n_mack, np = n_stop;
    for (int i = 0; i < n; i++) rd_src[i] = 8'($urandom);
    rd_i = 0;
    step(1, a, 1, 8'h00, 0, rd, nk);
    chk(nk == 0, "R6", "read address ack", int'(nk), 0);
    for (int i = 0; i < n; i++) begin
      step(0, a, 1, 8'h00, (i == n - 1), rd, nk);
      chk(rd == rd_src[i], "R8", "read byte", int'(rd), int'(rd_src[i]));
      chk(nk == 0, "R8", "no error on read", int'(nk), 0);
    end
    chk(addr_log == first_byte(a, 1), "R5", "read address byte", int'(addr_log), int'(first_byte(a, 1)));
    for (int i = 0; i < n; i++)
      chk(m_ack[8'(nm + i)] == (i == n - 1), "R8", "controller ack bit",
          int'(m_ack[8'(nm + i)]), int'(i == n - 1));
    chk(n_stop == np + 1, "R8", "stop after read", n_stop - np, 1);
  endtask

  task automatic do_bad_addr(input logic [6:0] a, input logic rw);
    logic [7:0] rd;
    logic nk;
    int np = n_stop;
    step(1, a, rw, 8'h00, 0, rd, nk);
    chk(nk == 1, "R7", "address nack flagged", int'(nk), 1);
    chk(n_stop == np + 1, "R7", "stop on nack", n_stop - np, 1);
    chk(busy == 0 && scl_oe == 0 && sda_oe == 0, "R7", "released after nack",
        int'({busy, scl_oe, sda_oe}), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    logic nk;
    int ns, nw;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1", "lines released after reset", int'({scl_oe, sda_oe}), 0);
    chk(busy == 0 && done == 0 && nack_error == 0, "R1", "status after reset",
        int'({busy, done, nack_error}), 0);

    // Directed write, then read
    cfg_div = 12'd5;
    do_write(SLV, 2);
    do_read(SLV, 3);

    // Address NACK, then write-byte NACK
    do_bad_addr(7'h11, 0);
    acc_wr = 0;
    ns = n_stop;
    step(1, SLV, 0, 8'h00, 0, rd, nk);
    step(0, SLV, 0, 8'hA5, 0, rd, nk);
    chk(nk == 1, "R7", "write nack flagged", int'(nk), 1);
    chk(n_stop == ns + 1 && busy == 0, "R7", "stop after write nack", n_stop - ns, 1);
    acc_wr = 1;

    // Repeated START: write one byte, then turn around into a read
    ns = n_start; nw = n_stop;
    rd_src[0] = 8'h3C; rd_src[1] = 8'hC3; rd_i = 0;
    step(1, SLV, 0, 8'h00, 0, rd, nk);
    step(0, SLV, 0, 8'h71, 0, rd, nk);
    chk(wr_log[8'(n_wr - 1)] == 8'h71, "R5", "byte before rstart", int'(wr_log[8'(n_wr - 1)]), 'h71);
    step(1, SLV, 1, 8'h00, 0, rd, nk);
    chk(n_start == ns + 2 && n_stop == nw, "R9", "repeated start without stop",
        (n_start - ns) * 16 + (n_stop - nw), 32);
    chk(addr_log == first_byte(SLV, 1), "R9", "address after rstart", int'(addr_log), int'(first_byte(SLV, 1)));
    step(0, SLV, 1, 8'h00, 0, rd, nk);
    chk(rd == 8'h3C, "R9", "read after rstart", int'(rd), 'h3C);
    step(0, SLV, 1, 8'h00, 1, rd, nk);
    chk(rd == 8'hC3, "R8", "last read byte", int'(rd), 'hC3);
    chk(n_stop == nw + 1, "R9", "single stop", n_stop - nw, 1);

    // Bus not free: the clock line is held low by someone else
    force_scl_low = 1;
    ns = n_start;
    issue(1, SLV, 0, 8'h00, 0);
    chk(busy == 1, "R2", "busy after accepted start", int'(busy), 1);
    repeat (40) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0 && n_start == ns, "R2", "no drive while bus busy",
        int'({scl_oe, sda_oe}), 0);
    force_scl_low = 0;
    wait_done(rd, nk);
    chk(nk == 0 && n_start == ns + 1, "R2", "start after bus freed", n_start - ns, 1);
    step(0, SLV, 0, 8'h0F, 1, rd, nk);
    chk(wr_log[8'(n_wr - 1)] == 8'h0F, "R2", "write after wait", int'(wr_log[8'(n_wr - 1)]), 'h0F);

    // Ignored commands
    ns = n_start; nw = n_wr;
    step(1, SLV, 0, 8'h00, 0, rd, nk);
    issue(0, SLV, 0, 8'h5C, 1);
    repeat (30) @(negedge clk);
    issue(1, 7'h33, 1, 8'hFF, 0);
    wait_done(rd, nk);
    chk(n_wr == nw + 1 && wr_log[8'(nw)] == 8'h5C, "R11", "go mid-step ignored",
        int'(wr_log[8'(nw)]), 'h5C);
    chk(n_start == ns + 1 && busy == 0, "R11", "no extra start", n_start - ns, 1);
    issue(0, SLV, 0, 8'h00, 0);
    repeat (60) @(negedge clk);
    chk(busy == 0 && scl_oe == 0 && sda_oe == 0 && n_start == ns + 1, "R11",
        "idle go without start ignored", int'({busy, scl_oe, sda_oe}), 0);

    // Divider corners
    cfg_div = 12'd0; do_write(SLV, 1);
    cfg_div = 12'd1; do_read(SLV, 1);
    cfg_div = 12'd12; do_write(SLV, 1);

    // Constrained random mix
    for (int t = 0; t < 16; t++) begin
      logic [6:0] a;
      logic rw;
      int n;
      cfg_div = 12'($urandom_range(0, 6));
      rw = 1'($urandom);
      n = int'($urandom_range(1, 3));
      a = ($urandom_range(0, 3) == 0) ? (SLV ^ 7'(1 + $urandom_range(0, 100))) : SLV;
      if (a != SLV) do_bad_addr(a, rw);
      else if (rw) do_read(a, n);
      else do_write(a, n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule